// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects eight active-low interrupt request lines for an 8-bit processor and sits in its memory map. A high-to-low transition on any request line sets a pending bit. A per-line mask decides whether that pending bit pulls the shared active-low interrupt output. When the processor services the interrupt it reads three consecutive bytes at the controller's fetch window: a long-branch opcode, then the high byte and low byte of a vector address. The vector is computed from a programmed base address, a programmed power-of-two spacing, and the highest-priority unmasked pending line. Fetching the opcode retires that line's pending bit.

Software writes the mask, the base address and the spacing, and reads a status byte that shows every pending line. Reading the status byte clears all pending bits. A cascade input takes the interrupt output of another controller. While that input is low, this controller forwards the interrupt and stays silent on the fetch window, so controllers can be chained eight levels at a time.

The register bus is a plain synchronous strobe interface with no back-pressure. A read returns its byte combinationally in the cycle that `cs` and `rd` are high. The side effects of that read (capture or clearing) take place at the closing clock edge. A write takes effect at the clock edge of its strobe cycle.

Top module: `vect_irq_ctrl`

## Requirements
- R1: A request line sets its pending bit only on a high-to-low transition. A line that is held low stays cleared after its pending bit is retired, and it sets again only after it goes high and then falls again.
- R2: The mask register is written at offset 4, and bit n = 1 masks line n. A masked line's falling edge is still recorded as pending, but it never drives `int_n` low.
- R3: With `cascade_n` high, `int_n` is low while at least one unmasked line is pending. It returns high once none remains.
- R4: Priority is fixed: line 7 is highest and line 0 lowest. The fetch serves the highest unmasked pending line.
- R5: A read at offset 0 returns 0xC0. A read at offset 1 returns the vector high byte, and a read at offset 2 returns the vector low byte.
- R6: The base is written at offset 6 (high byte) and offset 7 (low byte). The spacing code is bits [1:0] at offset 5: code 0 gives 4 bytes, 1 gives 8, 2 gives 16 and 3 gives 32. The vector for level n is the base with bits below log2(spacing)+3 cleared, plus n × spacing.
- R7: A read at offset 0 clears the pending bit of the line it serves and leaves all other pending bits untouched.
- R8: A read at offset 3 returns the pending bits (bit n = line n, masked or not) and clears all of them. A falling edge that arrives in the same cycle is still recorded.
- R9: The served level is captured at the offset-0 read and held for the offset-1 and offset-2 reads, even if new requests arrive in between.
- R10: While `cascade_n` is low, `int_n` is low. Reads at offsets 0, 1 and 2 return 0x00, and they capture and clear nothing.
- R11: After reset, no line is pending, all lines are masked, the base and spacing code are zero, `int_n` is high, and `rdata` is 0x00 when no read is active.
- R12: An offset-0 read with no unmasked line pending returns 0xC0 and the vector for level 0, and it clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for the register bus |
| addr | input | 3 | Register offset |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| irq_n | input | 8 | Active-low request lines, falling-edge sensitive |
| cascade_n | input | 1 | Interrupt output of an upstream controller |
| int_n | output | 1 | Active-low interrupt to the processor |

## Verification
The vector path is tried with single requests and with several lines falling together, across all four spacing codes and two base values. This separates errors in priority order from errors in base masking or shift amount. A request that arrives between the opcode read and the address reads shows whether the level is held. A line held low after service shows whether the latch triggers on the edge or on the level. A status read with a coincident falling edge, a fully masked pending set, and a low cascade input separate the clear-all path, the mask gating and the fetch silencing from the ordinary service path.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned SEL_W            = 3;
  localparam int unsigned SPACING_CODE_W   = 2;
  localparam int unsigned SPACING_MIN_LOG2 = 2;
  localparam logic [7:0]  LBR_OPCODE       = 8'hC0;

  // Offsets 0..2 form the fetch window and must stay consecutive.
  typedef enum logic [SEL_W-1:0] {
    SEL_FETCH_OP = 3'd0,
    SEL_FETCH_HI = 3'd1,
    SEL_FETCH_LO = 3'd2,
    SEL_STATUS   = 3'd3,
    SEL_MASK     = 3'd4,
    SEL_SPACING  = 3'd5,
    SEL_BASE_HI  = 3'd6,
    SEL_BASE_LO  = 3'd7
  } vic_sel_e;
endpackage

// File: rtl/vic_edge_latch.sv
module vic_edge_latch #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_n,
  input  logic [N_LINES-1:0] clr_vec,
  output logic [N_LINES-1:0] fall_vec,
  output logic [N_LINES-1:0] pend
);
  logic [N_LINES-1:0] prev_q;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    // previous sample resets low so a line already low at reset is not an edge
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= irq_n[i];
    end

    assign fall_vec[i] = prev_q[i] & ~irq_n[i];

    // a new edge wins over a clear in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= (pend[i] & ~clr_vec[i]) | fall_vec[i];
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned LVL_W   = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] req,
  output logic               any_req,
  output logic [LVL_W-1:0]   top_lvl
);
  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (req[i]) top_lvl = LVL_W'(i);
    end
  end

  assign any_req = |req;
endmodule

// File: rtl/vic_vec_gen.sv
module vic_vec_gen
  import vic_pkg::*;
#(
  parameter int unsigned VEC_W = 16,
  parameter int unsigned LVL_W = 3
) (
  input  logic [VEC_W-1:0]          base,
  input  logic [SPACING_CODE_W-1:0] code,
  input  logic [LVL_W-1:0]          lvl,
  output logic [VEC_W-1:0]          vec
);
  int unsigned        step_log2;
  logic [VEC_W-1:0]   keep_mask;

  always_comb begin
    step_log2 = SPACING_MIN_LOG2 + int'(code);
    keep_mask = {VEC_W{1'b1}} << (step_log2 + LVL_W);
    vec       = (base & keep_mask) | (VEC_W'(lvl) << step_log2);
  end
endmodule

// File: rtl/vect_irq_ctrl.sv
module vect_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned VEC_W   = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic [SEL_W-1:0]   addr,
  input  logic               rd,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [N_LINES-1:0] irq_n,
  input  logic               cascade_n,
  output logic               int_n
);
  localparam int unsigned LVL_W = $clog2(N_LINES);

  vic_sel_e                  sel;
  logic                      acc_rd, acc_wr, op_rd, stat_rd;
  logic [N_LINES-1:0]        mask_q, pend, fall_vec, clr_vec, active;
  logic [VEC_W-1:0]          base_q, vec;
  logic [SPACING_CODE_W-1:0] code_q;
  logic [LVL_W-1:0]          top_lvl, lvl_q;
  logic                      any_act;

  assign sel     = vic_sel_e'(addr);
  assign acc_rd  = cs & rd;
  assign acc_wr  = cs & wr;
  assign op_rd   = acc_rd & (sel == SEL_FETCH_OP) & cascade_n;
  assign stat_rd = acc_rd & (sel == SEL_STATUS);
  assign active  = pend & ~mask_q;

  vic_edge_latch #(.N_LINES(N_LINES)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_n    (irq_n),
    .clr_vec  (clr_vec),
    .fall_vec (fall_vec),
    .pend     (pend)
  );

  vic_prio #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_prio (
    .req     (active),
    .any_req (any_act),
    .top_lvl (top_lvl)
  );

  vic_vec_gen #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_vec (
    .base (base_q),
    .code (code_q),
    .lvl  (lvl_q),
    .vec  (vec)
  );

  always_comb begin
    clr_vec = '0;
    if (stat_rd)               clr_vec = '1;
    else if (op_rd && any_act) clr_vec[top_lvl] = 1'b1;
  end

  // served level: captured at the opcode byte, held for the address bytes
  always_ff @(posedge clk) begin
    if (!rst_n)     lvl_q <= '0;
    else if (op_rd) lvl_q <= any_act ? top_lvl : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      base_q <= '0;
      code_q <= '0;
    end else if (acc_wr) begin
      case (sel)
        SEL_MASK:    mask_q <= wdata[N_LINES-1:0];
        SEL_SPACING: code_q <= wdata[SPACING_CODE_W-1:0];
        SEL_BASE_HI: base_q[VEC_W-1:DATA_W] <= wdata;
        SEL_BASE_LO: base_q[DATA_W-1:0] <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (acc_rd) begin
      case (sel)
        SEL_FETCH_OP: rdata = cascade_n ? DATA_W'(LBR_OPCODE) : '0;
        SEL_FETCH_HI: rdata = cascade_n ? vec[VEC_W-1:DATA_W] : '0;
        SEL_FETCH_LO: rdata = cascade_n ? vec[DATA_W-1:0] : '0;
        SEL_STATUS:   rdata = DATA_W'(pend);
        default:      rdata = '0;
      endcase
    end
  end

  assign int_n = ~(any_act | ~cascade_n);
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned LVL_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs,
  input logic               rd,
  input logic [2:0]         addr,
  input logic [7:0]         rdata,
  input logic [N_LINES-1:0] irq_n,
  input logic               cascade_n,
  input logic               int_n,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] fall_vec,
  input logic [LVL_W-1:0]   top_lvl,
  input logic [LVL_W-1:0]   lvl_q,
  input logic               any_act
);
  logic warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;
  end

  logic op_rd_c, stat_rd_c;
  assign op_rd_c   = cs && rd && addr == 3'd0 && cascade_n;
  assign stat_rd_c = cs && rd && addr == 3'd3;

  for (genvar i = 0; i < N_LINES; i++) begin : g_r1
    p_fall_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $fell(irq_n[i])) |=> pend[i]);
  end

  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1 && cascade_n) |-> int_n);

  p_prio_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_act |-> ((pend & ~mask_q) >> top_lvl) == 1);

  p_opcode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_rd_c |-> rdata == 8'hC0);

  p_serve_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_rd_c && any_act && fall_vec == '0) |=> !pend[$past(top_lvl)]);

  p_status_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_c && fall_vec == '0) |=> pend == '0);

  p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !op_rd_c) |=> $stable(lvl_q));

  p_cascade_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cascade_n |-> !int_n);

  p_cascade_mute_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cascade_n && cs && rd && addr <= 3'd2) |-> rdata == 8'h00);
endmodule

bind vect_irq_ctrl vic_checker #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs        (cs),
  .rd        (rd),
  .addr      (addr),
  .rdata     (rdata),
  .irq_n     (irq_n),
  .cascade_n (cascade_n),
  .int_n     (int_n),
  .pend      (pend),
  .mask_q    (mask_q),
  .fall_vec  (fall_vec),
  .top_lvl   (top_lvl),
  .lvl_q     (lvl_q),
  .any_act   (any_act)
);

// File: tb/tb_vect_irq_ctrl.sv
module tb_vect_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irq_n = 8'hFF;
  logic       cascade_n = 1'b1;
  logic       int_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  vect_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .cascade_n(cascade_n),
    .int_n(int_n)
  );

  // monitor: samples shortly before the rising edge
  always begin
    @(negedge clk);
    #4;
    if (cs && rd) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: rdata=%h expected none", rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rdata !== e.exp) begin
          n_bad++;
          $display("FAIL %s: rdata=%h expected %h", e.tag, rdata, e.exp);
        end
      end
    end
  end

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    sb_q.push_back('{exp: exp, tag: tag});
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    irq_n = irq_n & ~m;
    @(negedge clk);
    irq_n = irq_n | m;
  endtask

  task automatic int_chk(input logic exp, input string tag);
    @(negedge clk);
    #4;
    n_chk++;
    if (int_n !== exp) begin
      n_bad++;
      $display("FAIL %s: int_n=%b expected %b", tag, int_n, exp);
    end
  endtask

  task automatic fetch(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    rd_chk(3'd0, 8'hC0, {tag, " R5 opcode"});
    rd_chk(3'd1, hi, {tag, " R6 vector hi"});
    rd_chk(3'd2, lo, {tag, " R6 vector lo"});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    int_chk(1'b1, "R11 int idle");
    @(negedge clk); #4;
    n_chk++;
    if (rdata !== 8'h00) begin
      n_bad++;
      $display("FAIL R11 idle rdata: rdata=%h expected 00", rdata);
    end
    rd_chk(3'd3, 8'h00, "R11 status empty");
    fetch(8'h00, 8'h00, "R11 R12 empty fetch");

    // R2: masked line latches, int stays high
    pulse(8'h08);
    int_chk(1'b1, "R2 masked quiet");
    rd_chk(3'd3, 8'h08, "R2 R8 status shows masked");
    rd_chk(3'd3, 8'h00, "R8 status cleared");

    // R3/R6/R7: single request, spacing 4
    wr_reg(3'd4, 8'h00);
    wr_reg(3'd6, 8'h12);
    wr_reg(3'd7, 8'h34);
    wr_reg(3'd5, 8'h00);
    pulse(8'h04);
    int_chk(1'b0, "R3 int asserted");
    fetch(8'h12, 8'h28, "R6 code0 lvl2");
    int_chk(1'b1, "R3 R7 int released");

    // R4: several lines at once, spacing 8
    wr_reg(3'd5, 8'h01);
    pulse(8'h62);
    int_chk(1'b0, "R4 int asserted");
    fetch(8'h12, 8'h30, "R4 lvl6 first");
    fetch(8'h12, 8'h28, "R4 R7 lvl5 next");
    fetch(8'h12, 8'h08, "R4 R7 lvl1 last");
    int_chk(1'b1, "R7 all served");

    // R6: spacing 32 and 16 with another base
    wr_reg(3'd6, 8'hAB);
    wr_reg(3'd7, 8'hCD);
    wr_reg(3'd5, 8'h03);
    pulse(8'h80);
    fetch(8'hAB, 8'hE0, "R6 code3 lvl7");
    wr_reg(3'd5, 8'h02);
    pulse(8'h10);
    fetch(8'hAB, 8'hC0, "R6 code2 lvl4");

    // R9: new higher request between opcode and address bytes
    pulse(8'h04);
    rd_chk(3'd0, 8'hC0, "R9 opcode");
    pulse(8'h80);
    rd_chk(3'd1, 8'hAB, "R9 held hi");
    rd_chk(3'd2, 8'hA0, "R9 held lvl2 lo");
    int_chk(1'b0, "R9 late request pending");
    fetch(8'hAB, 8'hF0, "R9 lvl7 after");
    int_chk(1'b1, "R9 drained");

    // R1: held-low line does not retrigger
    @(negedge clk); irq_n[0] = 1'b0;
    int_chk(1'b0, "R1 edge latched");
    fetch(8'hAB, 8'h80, "R1 lvl0");
    int_chk(1'b1, "R1 no level retrigger");
    int_chk(1'b1, "R1 still quiet");
    @(negedge clk); irq_n[0] = 1'b1;
    pulse(8'h01);
    int_chk(1'b0, "R1 new edge latched");
    fetch(8'hAB, 8'h80, "R1 lvl0 again");

    // R8: edge in the same cycle as a status read survives
    wr_reg(3'd4, 8'hFF);
    pulse(8'h08);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = 3'd3; irq_n[4] = 1'b0;
    sb_q.push_back('{exp: 8'h08, tag: "R8 status before"});
    @(negedge clk);
    cs = 1'b0; rd = 1'b0; irq_n[4] = 1'b1;
    rd_chk(3'd3, 8'h10, "R8 coincident edge kept");
    rd_chk(3'd3, 8'h00, "R8 cleared");

    // R10: cascade input
    wr_reg(3'd4, 8'h00);
    @(negedge clk); cascade_n = 1'b0;
    int_chk(1'b0, "R10 forwarded");
    pulse(8'h02);
    rd_chk(3'd0, 8'h00, "R10 opcode muted");
    rd_chk(3'd1, 8'h00, "R10 hi muted");
    rd_chk(3'd2, 8'h00, "R10 lo muted");
    @(negedge clk); cascade_n = 1'b1;
    int_chk(1'b0, "R10 request not cleared");
    fetch(8'hAB, 8'h90, "R10 lvl1 after release");
    int_chk(1'b1, "R10 drained");

    // R2/R4: masked high line skipped by the fetch
    wr_reg(3'd4, 8'h80);
    pulse(8'h82);
    int_chk(1'b0, "R2 unmasked drives");
    fetch(8'hAB, 8'h90, "R2 R4 masked lvl7 skipped");
    int_chk(1'b1, "R2 masked left quiet");
    rd_chk(3'd3, 8'h80, "R2 R8 masked still pending");

    // R12: fetch with nothing pending
    fetch(8'hAB, 8'h80, "R12 empty fetch");
    int_chk(1'b1, "R12 nothing cleared or set");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d left, expected 0", sb_q.size());
    end
    summary();
  end
endmodule